// File: doc/BRIEF.md
# Cache bank power-mode policy controller

This controller sits beside a shared cache built from tiles, where every tile holds one fast volatile bank and one dense non-volatile partner bank. While a monitoring period runs it gathers activity for each tile: lines filled, lines dropped, hits on clean lines and hits on dirty lines. It also keeps cache-wide counts of reads, writes and misses. When the period-end strobe arrives, it grades every live tile on three axes: write-heavy or read-heavy traffic, high or low occupancy, and hot or cold. It then issues one command for that tile and moves the tile's two power enables.

A tile is judged by the volatile rule set while its volatile bank is on, and by the non-volatile rule set otherwise. A command is one of four things: switch the bank off, leave it as it is, move its valid lines to the partner and then switch it off, or wake the partner and copy lines into its replication area. Line moves are carried out by an external data mover. The source bank keeps its power until the mover acknowledges the move, and the tile is left alone until then.

Top module: `bankPowerPolicy`

## Requirements
- R1: After reset every volatile bank enable is 1, every non-volatile bank enable is 0, and no command pulse or migration request is raised.
- R2: Each tile's occupancy count rises by one on a fill pulse and falls by one on a drop pulse. A drop at zero is ignored, and a fill together with a drop leaves it unchanged. The count saturates at its all-ones maximum. It restarts at zero when a period ends, and events in the strobe cycle itself are discarded.
- R3: A tile is hot when at least one miss was seen in the period and (clean hits + dirty hits) × (number of tiles with any bank on) is strictly greater than the sum of hits over those tiles. Occupancy is high under the same strict mean rule. All hit, miss, read and write counters saturate and restart at each period end.
- R4: Traffic is write-heavy when the period's cache-wide write count is strictly greater than its read count, and read-heavy otherwise.
- R5: In the cycle after the strobe, cmdValid[t] pulses for every tile that has a bank on and no pending migration. cmdOnNv[t] is 0 when the volatile rules were used and 1 otherwise. The cmdCode[2t+1:2t] field gives the command: 0 off, 1 keep, 2 migrate, 3 replicate.
- R6: Volatile rules: cold and low occupancy gives 0. Hot and high occupancy gives 3. Read-heavy with exactly one of the two high gives 2. Write-heavy with only hotness high gives 2, and write-heavy with only occupancy high gives 1.
- R7: Non-volatile rules: cold and low occupancy gives 0. Hot with low occupancy gives 1. Hot with high occupancy gives 3. Cold with high occupancy gives 1 when read-heavy and 2 when write-heavy.
- R8: On a volatile command, 0 clears the volatile enable, 2 and 3 set the non-volatile enable, and 2 also starts a migration toward the non-volatile bank. On a non-volatile command, 0 clears the non-volatile enable and 2 sets the volatile enable and starts a migration toward the volatile bank. Keep and non-volatile replicate change no enable.
- R9: migReq[t] is high from the command cycle until the cycle after migAck[t]. While it is high, both enables stay on and stable, and migToVol[t] is 1 for a move into the volatile bank. The cycle after the acknowledge, the source bank's enable is 0. An acknowledge with no request pending changes nothing.
- R10: A tile with both banks off is never evaluated and raises no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periodEnd | input | 1 | Period-end strobe; decisions are taken on it |
| insertEv | input | NUM_TILES | Line filled into the tile |
| dropEv | input | NUM_TILES | Line invalidated or evicted from the tile |
| cleanHitEv | input | NUM_TILES | Hit on a clean line of the tile |
| dirtyHitEv | input | NUM_TILES | Hit on a dirty line of the tile |
| rdEv | input | 1 | Shared-cache read |
| wrEv | input | 1 | Shared-cache write |
| missEv | input | 1 | Shared-cache miss |
| migAck | input | NUM_TILES | Data mover finished the tile's migration |
| volPwrEn | output | NUM_TILES | Volatile bank power enable |
| nvPwrEn | output | NUM_TILES | Non-volatile bank power enable |
| cmdValid | output | NUM_TILES | One-cycle pulse: a command was issued |
| cmdCode | output | 2*NUM_TILES | Command per tile |
| cmdOnNv | output | NUM_TILES | Command came from the non-volatile rules |
| migReq | output | NUM_TILES | Migration pending for the tile |
| migToVol | output | NUM_TILES | Pending migration moves lines into the volatile bank |

## Verification
The properties assume that the data mover raises migAck for a tile only as a single-cycle pulse. They also assume the strobe is a one-cycle pulse with at least one idle cycle after it. The stimulus keeps periods between five and about thirty-five cycles long. It sends acknowledges as independent one-cycle pulses, so some of them land on tiles with nothing pending. The reference model then checks that those stray pulses are ignored rather than relying on the mover being well behaved.

// File: rtl/bankPolicyPkg.sv
package bankPolicyPkg;

  typedef enum logic [1:0] {
    ACT_OFF       = 2'd0,
    ACT_KEEP      = 2'd1,
    ACT_MIGRATE   = 2'd2,
    ACT_REPLICATE = 2'd3
  } bankAct_e;

  // strobes from control to the statistics datapath
  typedef struct packed {
    logic clearStats;
    logic countEnable;
  } statStrobe_t;

  // decision for a tile whose volatile bank is on
  function automatic bankAct_e volTable(input logic writeHeavy, input logic utilHi,
                                        input logic hotHi);
    bankAct_e act;
    unique case ({utilHi, hotHi})
      2'b00:   act = ACT_OFF;
      2'b11:   act = ACT_REPLICATE;
      2'b10:   act = writeHeavy ? ACT_KEEP : ACT_MIGRATE;
      default: act = ACT_MIGRATE;
    endcase
    return act;
  endfunction

  // decision for a tile served by its non-volatile bank only
  function automatic bankAct_e nvTable(input logic writeHeavy, input logic utilHi,
                                       input logic hotHi);
    bankAct_e act;
    unique case ({utilHi, hotHi})
      2'b00:   act = ACT_OFF;
      2'b01:   act = ACT_KEEP;
      2'b10:   act = writeHeavy ? ACT_MIGRATE : ACT_KEEP;
      default: act = ACT_REPLICATE;
    endcase
    return act;
  endfunction

endpackage

// File: rtl/bankPolicyStats.sv
module bankPolicyStats
  import bankPolicyPkg::*;
#(
  parameter int NUM_TILES = 16,
  parameter int CNT_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  statStrobe_t          strb,
  input  logic [NUM_TILES-1:0] poweredMask,
  input  logic [NUM_TILES-1:0] insertEv,
  input  logic [NUM_TILES-1:0] dropEv,
  input  logic [NUM_TILES-1:0] cleanHitEv,
  input  logic [NUM_TILES-1:0] dirtyHitEv,
  input  logic                 rdEv,
  input  logic                 wrEv,
  input  logic                 missEv,
  output logic [NUM_TILES-1:0] utilHigh,
  output logic [NUM_TILES-1:0] hotHigh,
  output logic                 writeHeavy
);

  localparam int IDX_W = $clog2(NUM_TILES + 1);
  localparam int HOT_W = CNT_W + 1;
  localparam int SUM_W = HOT_W + IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  // cache-wide counters
  logic [CNT_W-1:0] rdCnt, wrCnt, missCnt;

  always_ff @(posedge clk) begin
    if (!rst_n || strb.clearStats) begin
      rdCnt   <= '0;
      wrCnt   <= '0;
      missCnt <= '0;
    end else if (strb.countEnable) begin
      if (rdEv)   rdCnt   <= satInc(rdCnt);
      if (wrEv)   wrCnt   <= satInc(wrCnt);
      if (missEv) missCnt <= satInc(missCnt);
    end
  end

  assign writeHeavy = wrCnt > rdCnt;

  // per-tile counters
  logic [CNT_W-1:0] utilVec [NUM_TILES];
  logic [HOT_W-1:0] hotVec  [NUM_TILES];

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
    logic [CNT_W-1:0] utilCnt, cleanCnt, dirtyCnt;

    always_ff @(posedge clk) begin
      if (!rst_n || strb.clearStats) begin
        utilCnt  <= '0;
        cleanCnt <= '0;
        dirtyCnt <= '0;
      end else if (strb.countEnable) begin
        unique case ({insertEv[t], dropEv[t]})
          2'b10:   utilCnt <= satInc(utilCnt);
          2'b01:   if (utilCnt != '0) utilCnt <= utilCnt - 1'b1;
          default: ;
        endcase
        if (cleanHitEv[t]) cleanCnt <= satInc(cleanCnt);
        if (dirtyHitEv[t]) dirtyCnt <= satInc(dirtyCnt);
      end
    end

    assign utilVec[t] = utilCnt;
    assign hotVec[t]  = {1'b0, cleanCnt} + {1'b0, dirtyCnt};
  end

  // sums over tiles with any bank on
  logic [SUM_W-1:0] utilSum, hotSum, liveCnt;

  always_comb begin
    utilSum = '0;
    hotSum  = '0;
    liveCnt = '0;
    for (int t = 0; t < NUM_TILES; t++) begin
      if (poweredMask[t]) begin
        utilSum = utilSum + SUM_W'(utilVec[t]);
        hotSum  = hotSum + SUM_W'(hotVec[t]);
        liveCnt = liveCnt + 1'b1;
      end
    end
  end

  // above-mean tests: value * count > sum
  for (genvar t = 0; t < NUM_TILES; t++) begin : g_cmp
    logic [SUM_W-1:0] utilScaled, hotScaled;
    assign utilScaled  = SUM_W'(utilVec[t]) * liveCnt;
    assign hotScaled   = SUM_W'(hotVec[t]) * liveCnt;
    assign utilHigh[t] = utilScaled > utilSum;
    assign hotHigh[t]  = (missCnt != '0) && (hotScaled > hotSum);
  end

endmodule

// File: rtl/bankPolicyCtrl.sv
module bankPolicyCtrl
  import bankPolicyPkg::*;
#(
  parameter int NUM_TILES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   periodEnd,
  input  logic [NUM_TILES-1:0]   utilHigh,
  input  logic [NUM_TILES-1:0]   hotHigh,
  input  logic                   writeHeavy,
  input  logic [NUM_TILES-1:0]   migAck,
  output statStrobe_t            strb,
  output logic [NUM_TILES-1:0]   poweredMask,
  output logic [NUM_TILES-1:0]   volPwrEn,
  output logic [NUM_TILES-1:0]   nvPwrEn,
  output logic [NUM_TILES-1:0]   cmdValid,
  output logic [2*NUM_TILES-1:0] cmdCode,
  output logic [NUM_TILES-1:0]   cmdOnNv,
  output logic [NUM_TILES-1:0]   migReq,
  output logic [NUM_TILES-1:0]   migToVol
);

  assign strb.clearStats  = periodEnd;
  assign strb.countEnable = !periodEnd;
  assign poweredMask      = volPwrEn | nvPwrEn;

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
    logic     volOn, nvOn, pend, toVol, valid, onNv;
    bankAct_e code, pick;
    logic     evalNow;

    assign evalNow = periodEnd && (volOn || nvOn) && !pend;
    assign pick    = volOn ? volTable(writeHeavy, utilHigh[t], hotHigh[t])
                           : nvTable(writeHeavy, utilHigh[t], hotHigh[t]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        volOn <= 1'b1;
        nvOn  <= 1'b0;
        pend  <= 1'b0;
        toVol <= 1'b0;
        valid <= 1'b0;
        onNv  <= 1'b0;
        code  <= ACT_KEEP;
      end else begin
        valid <= evalNow;
        // completion of a pending move: drop the source bank
        if (pend && migAck[t]) begin
          pend <= 1'b0;
          if (toVol) nvOn  <= 1'b0;
          else       volOn <= 1'b0;
        end
        if (evalNow) begin
          code <= pick;
          onNv <= !volOn;
          if (volOn) begin
            unique case (pick)
              ACT_OFF:       volOn <= 1'b0;
              ACT_MIGRATE:   begin nvOn <= 1'b1; pend <= 1'b1; toVol <= 1'b0; end
              ACT_REPLICATE: nvOn <= 1'b1;
              default:       ;
            endcase
          end else begin
            unique case (pick)
              ACT_OFF:     nvOn <= 1'b0;
              ACT_MIGRATE: begin volOn <= 1'b1; pend <= 1'b1; toVol <= 1'b1; end
              default:     ;
            endcase
          end
        end
      end
    end

    assign volPwrEn[t]        = volOn;
    assign nvPwrEn[t]         = nvOn;
    assign cmdValid[t]        = valid;
    assign cmdCode[2*t +: 2]  = code;
    assign cmdOnNv[t]         = onNv;
    assign migReq[t]          = pend;
    assign migToVol[t]        = toVol;
  end

endmodule

// File: rtl/bankPowerPolicy.sv
module bankPowerPolicy
  import bankPolicyPkg::*;
#(
  parameter int NUM_TILES = 16,
  parameter int CNT_W     = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   periodEnd,
  input  logic [NUM_TILES-1:0]   insertEv,
  input  logic [NUM_TILES-1:0]   dropEv,
  input  logic [NUM_TILES-1:0]   cleanHitEv,
  input  logic [NUM_TILES-1:0]   dirtyHitEv,
  input  logic                   rdEv,
  input  logic                   wrEv,
  input  logic                   missEv,
  input  logic [NUM_TILES-1:0]   migAck,
  output logic [NUM_TILES-1:0]   volPwrEn,
  output logic [NUM_TILES-1:0]   nvPwrEn,
  output logic [NUM_TILES-1:0]   cmdValid,
  output logic [2*NUM_TILES-1:0] cmdCode,
  output logic [NUM_TILES-1:0]   cmdOnNv,
  output logic [NUM_TILES-1:0]   migReq,
  output logic [NUM_TILES-1:0]   migToVol
);

  statStrobe_t          strb;
  logic [NUM_TILES-1:0] poweredMask, utilHigh, hotHigh;
  logic                 writeHeavy;

  bankPolicyStats #(.NUM_TILES(NUM_TILES), .CNT_W(CNT_W)) stats_i (
    .clk, .rst_n, .strb, .poweredMask,
    .insertEv, .dropEv, .cleanHitEv, .dirtyHitEv,
    .rdEv, .wrEv, .missEv,
    .utilHigh, .hotHigh, .writeHeavy
  );

  bankPolicyCtrl #(.NUM_TILES(NUM_TILES)) ctrl_i (
    .clk, .rst_n, .periodEnd, .utilHigh, .hotHigh, .writeHeavy, .migAck,
    .strb, .poweredMask, .volPwrEn, .nvPwrEn, .cmdValid, .cmdCode,
    .cmdOnNv, .migReq, .migToVol
  );

endmodule

// File: rtl/bankPowerPolicy_chk.sv
module bankPowerPolicy_chk
  import bankPolicyPkg::*;
#(
  parameter int NUM_TILES = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   periodEnd,
  input logic [NUM_TILES-1:0]   migAck,
  input logic [NUM_TILES-1:0]   volPwrEn,
  input logic [NUM_TILES-1:0]   nvPwrEn,
  input logic [NUM_TILES-1:0]   cmdValid,
  input logic [2*NUM_TILES-1:0] cmdCode,
  input logic [NUM_TILES-1:0]   migReq,
  input logic [NUM_TILES-1:0]   migToVol
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (volPwrEn == '1 && nvPwrEn == '0 && migReq == '0 && cmdValid == '0));

  // R5
  cmd_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmdValid) |-> $past(periodEnd));

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
    // R9
    pwr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (migReq[t] && !migAck[t]) |=> ($stable(volPwrEn[t]) && $stable(nvPwrEn[t])));

    // R9
    both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      migReq[t] |-> (volPwrEn[t] && nvPwrEn[t]));

    // R8
    mig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(migReq[t]) |-> (cmdValid[t] && cmdCode[2*t +: 2] == ACT_MIGRATE));

    // R9
    src_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (migReq[t] && migAck[t]) |=>
        (!migReq[t] && (migToVol[t] ? !nvPwrEn[t] : !volPwrEn[t])));

    // R10
    dead_tile_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!volPwrEn[t] && !nvPwrEn[t]) |=> !cmdValid[t]);
  end

endmodule

bind bankPowerPolicy bankPowerPolicy_chk #(.NUM_TILES(NUM_TILES)) chk_i (
  .clk(clk), .rst_n(rst_n), .periodEnd(periodEnd), .migAck(migAck),
  .volPwrEn(volPwrEn), .nvPwrEn(nvPwrEn), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .migReq(migReq), .migToVol(migToVol)
);

// File: tb/bankPowerPolicy_tb_top.sv
module bankPowerPolicy_tb_top;

  localparam int N    = 4;
  localparam int W    = 6;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic periodEnd = 1'b0;
  logic [N-1:0] insertEv = '0, dropEv = '0, cleanHitEv = '0, dirtyHitEv = '0, migAck = '0;
  logic rdEv = 1'b0, wrEv = 1'b0, missEv = 1'b0;
  logic [N-1:0]   volPwrEn, nvPwrEn, cmdValid, cmdOnNv, migReq, migToVol;
  logic [2*N-1:0] cmdCode;

  always #2 clk = ~clk;

  bankPowerPolicy #(.NUM_TILES(N), .CNT_W(W)) dut_i (
    .clk, .rst_n, .periodEnd, .insertEv, .dropEv, .cleanHitEv, .dirtyHitEv,
    .rdEv, .wrEv, .missEv, .migAck, .volPwrEn, .nvPwrEn, .cmdValid, .cmdCode,
    .cmdOnNv, .migReq, .migToVol
  );

  int checks = 0, fails = 0, cycles = 0;

  // reference model state
  int mUtil[N], mClean[N], mDirty[N];
  int mRd, mWr, mMiss;
  bit mVol[N], mNv[N], mPend[N], mToVol[N];
  bit eValid[N], eOnNv[N], eDead[N];
  int eCode[N];
  int pIns[N], pDrop[N], pHit[N];
  int pRd, pWr, pMiss;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sat(int v);
    return (v >= MAXV) ? MAXV : v + 1;
  endfunction

  // R6 rules
  function automatic int volRef(bit wh, bit uh, bit hh);
    if (!uh && !hh) return 0;
    if (uh && hh)   return 3;
    if (uh && wh)   return 1;
    return 2;
  endfunction

  // R7 rules
  function automatic int nvRef(bit wh, bit uh, bit hh);
    if (!uh && !hh) return 0;
    if (uh && hh)   return 3;
    if (hh)         return 1;
    return wh ? 2 : 1;
  endfunction

  task automatic modelReset();
    for (int t = 0; t < N; t++) begin
      mUtil[t] = 0; mClean[t] = 0; mDirty[t] = 0;
      mVol[t] = 1; mNv[t] = 0; mPend[t] = 0; mToVol[t] = 0;
      eValid[t] = 0; eOnNv[t] = 0; eDead[t] = 0; eCode[t] = 0;
    end
    mRd = 0; mWr = 0; mMiss = 0;
  endtask

  // model of one clock edge using the inputs held across it
  task automatic modelEdge();
    bit prePend[N];
    bit prePow[N];
    int live, uSum, hSum;
    bit wh;
    live = 0; uSum = 0; hSum = 0;
    wh = mWr > mRd;
    for (int t = 0; t < N; t++) begin
      prePend[t] = mPend[t];
      prePow[t]  = mVol[t] | mNv[t];
      eValid[t]  = 0;
      eDead[t]   = !prePow[t];
      if (prePow[t]) begin
        live++; uSum += mUtil[t]; hSum += mClean[t] + mDirty[t];
      end
    end
    for (int t = 0; t < N; t++) begin
      if (prePend[t] && migAck[t]) begin
        mPend[t] = 0;
        if (mToVol[t]) mNv[t] = 0; else mVol[t] = 0;
      end
    end
    if (periodEnd) begin
      for (int t = 0; t < N; t++) begin
        if (prePow[t] && !prePend[t]) begin
          bit uh, hh;
          uh = mUtil[t] * live > uSum;
          hh = (mMiss > 0) && ((mClean[t] + mDirty[t]) * live > hSum);
          eValid[t] = 1;
          eOnNv[t]  = !mVol[t];
          if (mVol[t]) begin
            eCode[t] = volRef(wh, uh, hh);
            if (eCode[t] == 0) mVol[t] = 0;
            if (eCode[t] == 2) begin mNv[t] = 1; mPend[t] = 1; mToVol[t] = 0; end
            if (eCode[t] == 3) mNv[t] = 1;
          end else begin
            eCode[t] = nvRef(wh, uh, hh);
            if (eCode[t] == 0) mNv[t] = 0;
            if (eCode[t] == 2) begin mVol[t] = 1; mPend[t] = 1; mToVol[t] = 1; end
          end
        end
        mUtil[t] = 0; mClean[t] = 0; mDirty[t] = 0;
      end
      mRd = 0; mWr = 0; mMiss = 0;
    end else begin
      for (int t = 0; t < N; t++) begin
        if (insertEv[t] && !dropEv[t]) mUtil[t] = sat(mUtil[t]);
        else if (dropEv[t] && !insertEv[t] && mUtil[t] > 0) mUtil[t]--;
        if (cleanHitEv[t]) mClean[t] = sat(mClean[t]);
        if (dirtyHitEv[t]) mDirty[t] = sat(mDirty[t]);
      end
      if (rdEv)   mRd   = sat(mRd);
      if (wrEv)   mWr   = sat(mWr);
      if (missEv) mMiss = sat(mMiss);
    end
  endtask

  task automatic compareAll(string codeTag);
    for (int t = 0; t < N; t++) begin
      chk("R8 volatile enable", int'(volPwrEn[t]), int'(mVol[t]));
      chk("R8 non-volatile enable", int'(nvPwrEn[t]), int'(mNv[t]));
      chk("R9 migration request", int'(migReq[t]), int'(mPend[t]));
      if (mPend[t]) chk("R9 direction", int'(migToVol[t]), int'(mToVol[t]));
      if (eDead[t]) chk("R10 dead tile pulse", int'(cmdValid[t]), 0);
      else          chk("R5 command pulse", int'(cmdValid[t]), int'(eValid[t]));
      if (eValid[t]) begin
        chk("R5 rule set", int'(cmdOnNv[t]), int'(eOnNv[t]));
        if (codeTag != "")  chk(codeTag, int'(cmdCode[2*t +: 2]), eCode[t]);
        else if (eOnNv[t])  chk("R3/R4/R7 command", int'(cmdCode[2*t +: 2]), eCode[t]);
        else                chk("R3/R4/R6 command", int'(cmdCode[2*t +: 2]), eCode[t]);
      end
    end
  endtask

  task automatic step(string codeTag);
    @(posedge clk);
    #1;
    modelEdge();
    compareAll(codeTag);
  endtask

  task automatic clearInputs();
    periodEnd = 0; insertEv = '0; dropEv = '0; cleanHitEv = '0; dirtyHitEv = '0;
    migAck = '0; rdEv = 0; wrEv = 0; missEv = 0;
  endtask

  task automatic resetDut();
    clearInputs();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1;
    modelReset();
    @(posedge clk);
    #1;
    for (int t = 0; t < N; t++) begin
      chk("R1 volatile on", int'(volPwrEn[t]), 1);
      chk("R1 non-volatile off", int'(nvPwrEn[t]), 0);
      chk("R1 no request", int'(migReq[t]), 0);
      chk("R1 no command", int'(cmdValid[t]), 0);
    end
  endtask

  task automatic randInputs(bit strobe);
    periodEnd = strobe;
    for (int t = 0; t < N; t++) begin
      insertEv[t]   = ($urandom % 16) < pIns[t];
      dropEv[t]     = ($urandom % 16) < pDrop[t];
      cleanHitEv[t] = ($urandom % 16) < pHit[t];
      dirtyHitEv[t] = ($urandom % 16) < pHit[t] / 2;
      migAck[t]     = ($urandom % 4) == 0;
    end
    rdEv   = ($urandom % 16) < pRd;
    wrEv   = ($urandom % 16) < pWr;
    missEv = ($urandom % 16) < pMiss;
  endtask

  task automatic driveTile(int t, bit ins, bit drp, int n);
    for (int i = 0; i < n; i++) begin
      clearInputs();
      insertEv[t] = ins;
      dropEv[t]   = drp;
      step("");
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    resetDut();

    // R2 directed: saturation, drop at zero, strobe-cycle discard
    driveTile(0, 1, 0, 70);
    driveTile(0, 0, 1, 5);
    driveTile(1, 1, 0, 20);
    driveTile(2, 0, 1, 3);
    driveTile(2, 1, 0, 2);
    clearInputs();
    periodEnd = 1;
    insertEv  = '1;
    step("R2 occupancy command");
    clearInputs();
    for (int i = 0; i < 6; i++) step("");
    // second period: fills only on tile3 now; strobe-cycle fills were dropped
    driveTile(3, 1, 0, 3);
    clearInputs();
    periodEnd = 1;
    step("R2 restart command");
    clearInputs();

    for (int p = 0; p < 120; p++) begin
      bit anyOn;
      int len;
      for (int t = 0; t < N; t++) begin
        pIns[t]  = $urandom % 12;
        pDrop[t] = $urandom % 8;
        pHit[t]  = $urandom % 14;
      end
      pRd   = $urandom % 12;
      pWr   = $urandom % 12;
      pMiss = (($urandom % 4) == 0) ? 0 : $urandom % 10 + 1;
      len = 5 + $urandom % 30;
      for (int c = 0; c < len; c++) begin
        randInputs(0);
        step("");
      end
      randInputs(1);
      step("");
      anyOn = 0;
      for (int t = 0; t < N; t++) anyOn |= mVol[t] | mNv[t];
      if (!anyOn || ($urandom % 25) == 0) resetDut();
    end

    clearInputs();
    repeat (3) step("");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule